// File: doc/BRIEF.md
# Cassette Controller Register Interface

This block sits between a processor bus and the transfer engine of a two-drive cassette tape controller. It holds a 16-bit control/status word and an 8-bit input and 8-bit output data buffer. Software reaches them at two word addresses picked by one address bit. The block merges the software-writable fields of the control word and issues a one-cycle start pulse to the engine when software sets the go bit while the engine is idle. It also keeps the transfer-request and ready flags and drives the interrupt request.

The engine reports conditions through set strobes that are ORed into the upper status bits. It can also raise a ready flag, request a byte transfer and load the input buffer. A byte transfer request that comes while the previous one is still unanswered is turned into a timing error. Tape motion, record storage and CRC arithmetic belong to the engine and are not part of this block.

Top module: `cassette_regs`

## Requirements
- R1: A synchronous active-high reset clears the control word, both data buffers, the start pulse, the start function/unit outputs and the interrupt request.
- R2: Control word layout: bit 15 error, 14 CRC error, 13 BOT/EOT, 12 write lock, 11 end of file, 10 timing error, 9 empty, 8 unit select, 7 transfer request, 6 interrupt enable, 5 ready, 4 start-CRC sequence, 3:1 function, 0 go. A control write (busAddr 0) changes only bits 8, 6, 4 and 3:1 (mask 0x015E). All other bits keep their value, and bit 0 always reads 0.
- R3: busByteEn[1] selects bits 15:8 and busByteEn[0] selects bits 7:0 of a control write. A lane that is not enabled keeps its old value.
- R4: A control write with busByteEn[0]=1 and busWData[0]=1 while engBusy is low starts an operation. goPulse is high for exactly the cycle after the write, and goFunc/goUnit carry the new function and unit fields. If engBusy is high, no pulse is produced.
- R5: Starting an operation clears bits 15:9, 7 and 5 of the control word. It clears the input buffer when the function is 2..7 and the output buffer when the function is 0 or 1.
- R6: After any control write that leaves the start-CRC bit (bit 4) set, the transfer request bit is 0.
- R7: A read at busAddr 1 returns the input buffer in bits 7:0 with bits 15:8 zero, and clears the transfer request on the following edge.
- R8: A write at busAddr 1 with busByteEn[0]=1 loads busWData[7:0] into the output buffer and clears the transfer request. A write there with only busByteEn[1] set changes neither the output buffer nor the transfer request.
- R9: engXferReq sets the transfer request when it is clear. When it is already set, it sets error (bit 15) and timing error (bit 10) instead. A data register access in the same cycle counts as answering the old request first.
- R10: engStatusSet[6:0] are ORed into bits 15:9 (index 6 to bit 15), and engReadySet sets bit 5. Both are applied after the start clear of R5.
- R11: intReq equals interrupt enable AND (transfer request OR ready), aligned with the control word it is computed from.
- R12: engDataLoad loads engData into the input buffer. It takes precedence over the start clear of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrite | input | 1 | One-cycle bus write strobe |
| busRead | input | 1 | One-cycle bus read strobe |
| busAddr | input | 1 | Word select: 0 control word, 1 data buffer |
| busByteEn | input | 2 | Byte lane enables for writes |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for the selected word (combinational) |
| engBusy | input | 1 | Engine is running an operation on some drive |
| engStatusSet | input | 7 | Set strobes for status bits 15:9 |
| engReadySet | input | 1 | Set strobe for ready |
| engXferReq | input | 1 | Engine asks for a byte transfer |
| engDataLoad | input | 1 | Load strobe for the input buffer |
| engData | input | 8 | Byte from the engine |
| outBuf | output | 8 | Output buffer toward the engine |
| goPulse | output | 1 | One-cycle start pulse |
| goFunc | output | 3 | Function of the last started operation |
| goUnit | output | 1 | Unit of the last started operation |
| intReq | output | 1 | Interrupt request |

## Verification
Every register effect of a bus or engine strobe shows up on the edge that samples the strobe. The control word, the buffers, goPulse and intReq therefore change one clock after the stimulus, while busRData follows busAddr in the same cycle. The bench drives its inputs on the falling edge, and a behavioural model advances on each rising edge. The model's expected values are compared with every output shortly after each falling edge, so each result is checked in the first half-cycle where it is due. Directed steps then read back specific control-word values that were worked out by hand for the corner cases.

// File: rtl/cassette_regs_pkg.sv
package cassette_regs_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned FUNC_W = 3;
  parameter int unsigned UNIT_W = 1;
  parameter int unsigned STS_W  = 7;

  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned ERR_B   = 15;
  localparam int unsigned TIM_B   = 10;
  localparam int unsigned STS_LO  = 9;
  localparam int unsigned UNIT_LO = 8;
  localparam int unsigned TR_B    = 7;
  localparam int unsigned IE_B    = 6;
  localparam int unsigned RDY_B   = 5;
  localparam int unsigned SEQ_B   = 4;
  localparam int unsigned FUNC_LO = 1;
  localparam int unsigned GO_B    = 0;

  localparam logic [WORD_W-1:0] WR_MASK   = 16'h015E;
  localparam logic [WORD_W-1:0] START_CLR = 16'hFEA0;

  typedef struct packed {
    logic csWrite;
    logic goAccept;
    logic outLoad;
    logic trTake;
    logic clrIn;
    logic clrOut;
  } strobe_t;
endpackage

// File: rtl/cassette_regs_ctrl.sv
module cassette_regs_ctrl
  import cassette_regs_pkg::*;
(
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              busAddr,
  input  logic [LANES-1:0]  busByteEn,
  input  logic              goBit,
  input  logic [FUNC_W-1:0] funcBits,
  input  logic              engBusy,
  output strobe_t           strb
);
  logic ctrlWr, dataWr, dataRd, isWriteFunc;

  always_comb begin
    ctrlWr      = busWrite && !busAddr;
    dataWr      = busWrite && busAddr && busByteEn[0];
    dataRd      = busRead && busAddr;
    isWriteFunc = (funcBits >> 1) == '0;
    strb.csWrite  = ctrlWr;
    strb.goAccept = ctrlWr && busByteEn[0] && goBit && !engBusy;
    strb.outLoad  = dataWr;
    strb.trTake   = dataWr || dataRd;
    strb.clrIn    = strb.goAccept && !isWriteFunc;
    strb.clrOut   = strb.goAccept && isWriteFunc;
  end
endmodule

// File: rtl/cassette_regs_dp.sv
module cassette_regs_dp
  import cassette_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [LANES-1:0]  busByteEn,
  input  logic [WORD_W-1:0] busWData,
  input  logic [STS_W-1:0]  engStatusSet,
  input  logic              engReadySet,
  input  logic              engXferReq,
  input  logic              engDataLoad,
  input  logic [BYTE_W-1:0] engData,
  output logic [WORD_W-1:0] csState,
  output logic [BYTE_W-1:0] inBuf,
  output logic [BYTE_W-1:0] outBuf,
  output logic              goPulse,
  output logic [FUNC_W-1:0] goFunc,
  output logic [UNIT_W-1:0] goUnit,
  output logic              intReq
);
  logic [WORD_W-1:0] merged, csNext;
  logic [BYTE_W-1:0] inNext, outNext;

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign merged[ln*BYTE_W +: BYTE_W] = busByteEn[ln] ? busWData[ln*BYTE_W +: BYTE_W]
                                                         : csState[ln*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    csNext = csState;
    if (strb.csWrite)
      csNext = (csState & ~WR_MASK) | (merged & WR_MASK);
    if (strb.goAccept)
      csNext = csNext & ~START_CLR;
    if (strb.trTake)
      csNext[TR_B] = 1'b0;
    csNext[STS_LO +: STS_W] = csNext[STS_LO +: STS_W] | engStatusSet;
    if (engReadySet)
      csNext[RDY_B] = 1'b1;
    if (engXferReq) begin
      if (csNext[TR_B]) begin
        csNext[ERR_B] = 1'b1;
        csNext[TIM_B] = 1'b1;
      end else begin
        csNext[TR_B] = 1'b1;
      end
    end
    if (strb.csWrite && csNext[SEQ_B])
      csNext[TR_B] = 1'b0;
    csNext[GO_B] = 1'b0;

    inNext = inBuf;
    if (strb.clrIn)  inNext = '0;
    if (engDataLoad) inNext = engData;

    outNext = outBuf;
    if (strb.clrOut)  outNext = '0;
    if (strb.outLoad) outNext = busWData[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csState <= '0;
      inBuf   <= '0;
      outBuf  <= '0;
      goPulse <= 1'b0;
      goFunc  <= '0;
      goUnit  <= '0;
      intReq  <= 1'b0;
    end else begin
      csState <= csNext;
      inBuf   <= inNext;
      outBuf  <= outNext;
      goPulse <= strb.goAccept;
      if (strb.goAccept) begin
        goFunc <= csNext[FUNC_LO +: FUNC_W];
        goUnit <= csNext[UNIT_LO +: UNIT_W];
      end
      intReq <= csNext[IE_B] && (csNext[TR_B] || csNext[RDY_B]);
    end
  end
endmodule

// File: rtl/cassette_regs.sv
module cassette_regs
  import cassette_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              busAddr,
  input  logic [1:0]        busByteEn,
  input  logic [15:0]       busWData,
  output logic [15:0]       busRData,
  input  logic              engBusy,
  input  logic [6:0]        engStatusSet,
  input  logic              engReadySet,
  input  logic              engXferReq,
  input  logic              engDataLoad,
  input  logic [7:0]        engData,
  output logic [7:0]        outBuf,
  output logic              goPulse,
  output logic [2:0]        goFunc,
  output logic              goUnit,
  output logic              intReq
);
  strobe_t           strb;
  logic [WORD_W-1:0] csState;
  logic [BYTE_W-1:0] inBuf;

  cassette_regs_ctrl u_ctrl (
    .busWrite  (busWrite),
    .busRead   (busRead),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .goBit     (busWData[GO_B]),
    .funcBits  (busWData[FUNC_LO +: FUNC_W]),
    .engBusy   (engBusy),
    .strb      (strb)
  );

  cassette_regs_dp u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .busByteEn    (busByteEn),
    .busWData     (busWData),
    .engStatusSet (engStatusSet),
    .engReadySet  (engReadySet),
    .engXferReq   (engXferReq),
    .engDataLoad  (engDataLoad),
    .engData      (engData),
    .csState      (csState),
    .inBuf        (inBuf),
    .outBuf       (outBuf),
    .goPulse      (goPulse),
    .goFunc       (goFunc),
    .goUnit       (goUnit),
    .intReq       (intReq)
  );

  assign busRData = busAddr ? {{(WORD_W-BYTE_W){1'b0}}, inBuf} : csState;
endmodule

// File: rtl/cassette_regs_chk.sv
module cassette_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        busWrite,
  input logic        busRead,
  input logic        busAddr,
  input logic [1:0]  busByteEn,
  input logic        goBit,
  input logic        engBusy,
  input logic        engXferReq,
  input logic [15:0] csState,
  input logic        goPulse,
  input logic        intReq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (csState == 16'h0 && !intReq && !goPulse));

  // R2
  go_not_stored_chk: assert property (@(posedge clk) disable iff (rst) !csState[0]);

  // R4
  go_source_chk: assert property (@(posedge clk) disable iff (rst)
    goPulse |-> $past(busWrite && !busAddr && busByteEn[0] && goBit && !engBusy));

  // R4
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busWrite && !busAddr && engBusy) |=> !goPulse);

  // R7
  read_take_chk: assert property (@(posedge clk) disable iff (rst)
    (busRead && busAddr && !engXferReq && !(busWrite && !busAddr)) |=> !csState[7]);

  // R9
  timing_err_chk: assert property (@(posedge clk) disable iff (rst)
    (engXferReq && csState[7] && !busRead && !busWrite) |=> (csState[15] && csState[10] && csState[7]));

  // R11
  int_align_chk: assert property (@(posedge clk) disable iff (rst)
    intReq == (csState[6] && (csState[7] || csState[5])));
endmodule

bind cassette_regs cassette_regs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busWrite   (busWrite),
  .busRead    (busRead),
  .busAddr    (busAddr),
  .busByteEn  (busByteEn),
  .goBit      (busWData[0]),
  .engBusy    (engBusy),
  .engXferReq (engXferReq),
  .csState    (csState),
  .goPulse    (goPulse),
  .intReq     (intReq)
);

// File: tb/cassette_regs_bench.sv
`timescale 1ns/100ps
module cassette_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrite = 0, busRead = 0, busAddr = 0;
  logic [1:0]  busByteEn = 0;
  logic [15:0] busWData = 0;
  logic [15:0] busRData;
  logic        engBusy = 0;
  logic [6:0]  engStatusSet = 0;
  logic        engReadySet = 0, engXferReq = 0, engDataLoad = 0;
  logic [7:0]  engData = 0;
  logic [7:0]  outBuf;
  logic        goPulse;
  logic [2:0]  goFunc;
  logic        goUnit;
  logic        intReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cassette_regs u_cassette_regs (
    .clk(clk), .rst(rst), .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWData(busWData), .busRData(busRData), .engBusy(engBusy),
    .engStatusSet(engStatusSet), .engReadySet(engReadySet), .engXferReq(engXferReq),
    .engDataLoad(engDataLoad), .engData(engData), .outBuf(outBuf), .goPulse(goPulse),
    .goFunc(goFunc), .goUnit(goUnit), .intReq(intReq)
  );

  // Behavioural reference state
  logic [15:0] mCs = 0;
  logic [7:0]  mIn = 0, mOut = 0;
  logic        mGo = 0, mUnit = 0, mInt = 0;
  logic [2:0]  mFunc = 0;

  always @(posedge clk) begin
    logic [15:0] nx, mrg;
    logic        wrCtl, start, take;
    if (rst) begin
      mCs = 0; mIn = 0; mOut = 0; mGo = 0; mFunc = 0; mUnit = 0; mInt = 0;
    end else begin
      nx = mCs;
      wrCtl = busWrite && !busAddr;
      mrg = mCs;
      if (busByteEn[1]) mrg[15:8] = busWData[15:8];
      if (busByteEn[0]) mrg[7:0]  = busWData[7:0];
      if (wrCtl) nx = (mCs & 16'hFEA1) | (mrg & 16'h015E);
      start = wrCtl && busByteEn[0] && busWData[0] && !engBusy;
      if (start) nx = nx & 16'h015F;
      if (start && busWData[3:1] >= 3'd2) mIn = 0;
      if (start && busWData[3:1] < 3'd2) mOut = 0;
      if (engDataLoad) mIn = engData;
      if (busWrite && busAddr && busByteEn[0]) mOut = busWData[7:0];
      take = busAddr && (busRead || (busWrite && busByteEn[0]));
      if (take) nx[7] = 0;
      nx[15:9] = nx[15:9] | engStatusSet;
      if (engReadySet) nx[5] = 1;
      if (engXferReq) begin
        if (nx[7]) nx = nx | 16'h8400;
        else nx[7] = 1;
      end
      if (wrCtl && nx[4]) nx[7] = 0;
      nx[0] = 0;
      mGo = start;
      if (start) begin mFunc = nx[3:1]; mUnit = nx[8]; end
      mInt = nx[6] && (nx[7] || nx[5]);
      mCs = nx;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model, every cycle
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      chk(busRData == (busAddr ? {8'h00, mIn} : mCs), busAddr ? "R7 data word" : "R2 control word",
          busRData, busAddr ? {8'h00, mIn} : mCs);
      chk(outBuf == mOut, "R8 output buffer", outBuf, mOut);
      chk(goPulse == mGo, "R4 start pulse", goPulse, mGo);
      chk({goUnit, goFunc} == {mUnit, mFunc}, "R4 start fields", {goUnit, goFunc}, {mUnit, mFunc});
      chk(intReq == mInt, "R11 interrupt", intReq, mInt);
    end
  end

  task automatic clearIn();
    busWrite = 0; busRead = 0; busByteEn = 0; busWData = 0;
    engStatusSet = 0; engReadySet = 0; engXferReq = 0; engDataLoad = 0; engData = 0;
  endtask

  task automatic busWr(input logic a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    busWrite = 1; busAddr = a; busByteEn = be; busWData = d;
    @(negedge clk);
    clearIn();
  endtask

  task automatic busRd(input logic a);
    @(negedge clk);
    busRead = 1; busAddr = a;
    @(negedge clk);
    clearIn();
  endtask

  task automatic eng(input logic [6:0] s, input logic rdy, input logic xr, input logic ld, input logic [7:0] d);
    @(negedge clk);
    engStatusSet = s; engReadySet = rdy; engXferReq = xr; engDataLoad = ld; engData = d;
    @(negedge clk);
    clearIn();
  endtask

  task automatic peek(input logic a, input string req, input logic [15:0] exp);
    busAddr = a;
    #2;
    chk(busRData == exp, req, busRData, exp);
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    peek(0, "R1 reset control word", 16'h0000);
    peek(1, "R1 reset input buffer", 16'h0000);
    chk(outBuf == 8'h00 && !intReq && !goPulse, "R1 reset outputs", {outBuf, intReq, goPulse}, 0);

    engBusy = 1;
    busWr(0, 2'b11, 16'hFFFF);
    chk(!goPulse, "R4 busy blocks start", goPulse, 0);
    peek(0, "R2 writable mask", 16'h015E);
    engBusy = 0;
    busWr(0, 2'b10, 16'h0000);
    peek(0, "R3 high lane only", 16'h005E);
    busWr(0, 2'b01, 16'h0000);
    peek(0, "R3 low lane only", 16'h0000);

    eng(7'h7F, 0, 0, 0, 0);
    peek(0, "R10 status OR", 16'hFE00);
    eng(0, 1, 0, 1, 8'h5A);
    peek(0, "R10 ready set", 16'hFE20);
    peek(1, "R12 input load", 16'h005A);

    busWr(0, 2'b01, 16'h0005);
    chk(goPulse && goFunc == 3'd2, "R4 start pulse func 2", {goPulse, goFunc}, {1'b1, 3'd2});
    peek(0, "R5 start clear", 16'h0004);
    peek(1, "R5 input buffer cleared", 16'h0000);

    eng(0, 0, 1, 1, 8'hC3);
    peek(0, "R9 request set", 16'h0084);
    eng(0, 0, 1, 0, 0);
    peek(0, "R9 timing error", 16'h8484);
    peek(1, "R7 read value", 16'h00C3);
    busRd(1);
    peek(0, "R7 read clears request", 16'h8404);

    busWr(0, 2'b01, 16'h0040);
    chk(!intReq, "R11 enable without cause", intReq, 0);
    eng(0, 1, 0, 0, 0);
    chk(intReq, "R11 ready interrupt", intReq, 1);
    eng(0, 0, 1, 0, 0);
    peek(0, "R9 request after ready", 16'h84E0);

    busWr(0, 2'b01, 16'h0050);
    peek(0, "R6 start-CRC clears request", 16'h8470);
    busWr(0, 2'b01, 16'h0040);
    eng(0, 0, 1, 0, 0);
    busWr(1, 2'b10, 16'hFF00);
    peek(0, "R8 odd byte ignored, request kept", 16'h84E0);
    chk(outBuf == 8'h00, "R8 odd byte ignored, buffer kept", outBuf, 0);
    busWr(1, 2'b01, 16'h00A5);
    chk(outBuf == 8'hA5, "R8 even byte load", outBuf, 8'hA5);
    peek(0, "R8 write clears request", 16'h8460);

    busWr(0, 2'b01, 16'h0003);
    chk(goPulse && goFunc == 3'd1, "R4 start pulse func 1", {goPulse, goFunc}, {1'b1, 3'd1});
    chk(outBuf == 8'h00, "R5 output buffer cleared", outBuf, 0);
    peek(0, "R5 start clear write func", 16'h0002);

    eng(0, 0, 0, 1, 8'h3C);
    peek(1, "R12 read upper zero", 16'h003C);

    lf = 32'hACE1_2468;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      busWrite = lf[0] & lf[1];
      busRead = lf[2];
      busAddr = lf[3];
      busByteEn = lf[5:4];
      busWData = lf[31:16];
      engBusy = lf[6];
      engStatusSet = lf[13:7] & {7{lf[14] & lf[15]}};
      engReadySet = lf[8] & lf[9];
      engXferReq = lf[10] & lf[11];
      engDataLoad = lf[12];
      engData = lf[23:16] ^ lf[31:24];
    end
    @(negedge clk);
    clearIn();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    peek(0, "R1 reset after traffic", 16'h0000);
    chk(outBuf == 8'h00 && !intReq, "R1 reset after traffic outputs", {outBuf, intReq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule